// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block keeps the exception-reporting part of a floating-point status/control register. Each time the floating-point datapath finishes an operation it presents five exception indications (invalid, divide-by-zero, overflow, underflow, inexact). The unit clears the per-operation flag field and rewrites it from those indications. It ORs the same bits into a sticky cause field. If any cause bit meets an enabled bit, it raises a trap request that carries a fixed exception code.

The unit also serves the datapath's mode controls. It decodes the rounding-mode field into a round-toward-zero select and exposes the denormal-flush bit. It keeps the T condition bit that equality and greater-than compares produce. A compare that comes out unordered does not touch T and takes the exception-update path instead. Software loads the whole register through a masked write port.

Top module: `fpu_exc_status`

## Requirements
- R1: After reset the status register, T bit and trap request are all zero.
- R2: A register load stores the written value ANDed with the writable mask 0x0005FFFF, so bits 17 and 19..31 always read zero. A load has priority over an operation completion or compare in the same cycle, and these are then ignored.
- R3: Rounding mode is bits [1:0]. Encoding 2'b01 asserts roundToZero, and every other encoding selects nearest-even (roundToZero low). Bit 18 set drives flushDenorm high.
- R4: On operation completion the flag field (bits [6:2]) is cleared and rewritten with bit 0=inexact, 1=underflow, 2=overflow, 3=divide-by-zero, 4=invalid (field bit n at register bit 2+n).
- R5: On operation completion the new flag bits are ORed into the cause field (bits [16:12], same bit order), and earlier cause bits are kept.
- R6: When at least one exception is reported and (cause after update) AND enable (bits [11:7], same bit order) is non-zero, trapReq goes high one cycle later, with trapCode = 0x120.
- R7: An operation that reports no exception leaves the flag field zero, leaves cause unchanged and raises no trap, even when cause and enable already overlap.
- R8: Once raised, trapReq stays high until a cycle with trapAck high and no new trap. A new trap in the ack cycle wins.
- R9: An ordered compare (cmpDone, cmpUnordered low) sets T to cmpGreater when cmpIsGt is 1, or to cmpEqual when it is 0, and leaves the register unchanged. Operation completion has priority over a compare in the same cycle.
- R10: An unordered compare leaves T unchanged and applies the R4 to R6 exception update using the exception inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldEn | input | 1 | Register load strobe |
| ldData | input | 32 | Value to load |
| opDone | input | 1 | Arithmetic operation completed |
| excInvalid | input | 1 | Invalid operation reported |
| excDivZero | input | 1 | Divide by zero reported |
| excOverflow | input | 1 | Overflow reported |
| excUnderflow | input | 1 | Underflow reported |
| excInexact | input | 1 | Inexact result reported |
| cmpDone | input | 1 | Compare completed |
| cmpIsGt | input | 1 | 1 = greater-than compare, 0 = equality compare |
| cmpEqual | input | 1 | Compare found operands equal |
| cmpGreater | input | 1 | Compare found first operand greater |
| cmpUnordered | input | 1 | Compare result unordered |
| trapAck | input | 1 | Acknowledge of the trap request |
| statusReg | output | 32 | Current status/control register |
| tBit | output | 1 | Compare condition bit |
| roundToZero | output | 1 | Round-toward-zero select for the datapath |
| flushDenorm | output | 1 | Denormal flush-to-zero enable |
| trapReq | output | 1 | Trap request, held until acknowledged |
| trapCode | output | 12 | Exception code of the trap (0x120) |

## Verification
Every stored result (register fields, T and trapReq) changes on the clock edge that samples the strobe, so it is due exactly one cycle after the stimulus. roundToZero and flushDenorm follow the register combinationally and so appear in that same cycle. The bench drives each strobe for one cycle from a falling edge and reads the outputs at the next falling edge, after that single register stage. The hold behaviour of the trap is checked again a few cycles later, and then after the acknowledge cycle.

// File: rtl/fpexc_pkg.sv
package fpexc_pkg;
  localparam int REG_W     = 32;
  localparam int FLD_W     = 5;
  localparam int RM_LSB    = 0;
  localparam int RM_W      = 2;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = FLAG_LSB + FLD_W;
  localparam int CAUSE_LSB = EN_LSB + FLD_W;
  localparam int FLUSH_BIT = CAUSE_LSB + FLD_W + 1;
  localparam logic [RM_W-1:0]  RM_ZERO = 2'b01;
  localparam logic [REG_W-1:0] WR_MASK = 32'h0005_FFFF;
  localparam int CODE_W    = 12;
  localparam logic [CODE_W-1:0] TRAP_CODE = 12'h120;

  // strobes from control to datapath
  typedef struct packed {
    logic ld;
    logic excUpd;
    logic tUpd;
    logic tVal;
  } strobe_t;
endpackage

// File: rtl/fpexc_ctrl.sv
module fpexc_ctrl
  import fpexc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ldEn,
  input  logic    opDone,
  input  logic    cmpDone,
  input  logic    cmpIsGt,
  input  logic    cmpEqual,
  input  logic    cmpGreater,
  input  logic    cmpUnordered,
  input  logic    trapAck,
  input  logic    trapHit,
  output strobe_t strb,
  output logic    trapReq
);
  logic cmpSel;

  // priority: load, then operation, then compare
  always_comb begin
    cmpSel      = cmpDone && !ldEn && !opDone;
    strb.ld     = ldEn;
    strb.excUpd = !ldEn && (opDone || (cmpSel && cmpUnordered));
    strb.tUpd   = cmpSel && !cmpUnordered;
    strb.tVal   = cmpIsGt ? cmpGreater : cmpEqual;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        trapReq <= 1'b0;
    else if (trapHit) trapReq <= 1'b1;
    else if (trapAck) trapReq <= 1'b0;
  end
endmodule

// File: rtl/fpexc_dp.sv
module fpexc_dp
  import fpexc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [REG_W-1:0] ldData,
  input  logic [FLD_W-1:0] excVec,
  output logic [REG_W-1:0] stReg,
  output logic             tBit,
  output logic             trapHit,
  output logic             roundToZero,
  output logic             flushDenorm
);
  logic [FLD_W-1:0] causeNow;
  logic [FLD_W-1:0] enNow;
  logic [FLD_W-1:0] causeNext;
  logic [REG_W-1:0] regNext;

  always_comb begin
    causeNow  = stReg[CAUSE_LSB +: FLD_W];
    enNow     = stReg[EN_LSB +: FLD_W];
    causeNext = causeNow | excVec;
    trapHit   = strb.excUpd && (|excVec) && (|(causeNext & enNow));
    regNext   = stReg;
    if (strb.ld) begin
      regNext = ldData & WR_MASK;
    end else if (strb.excUpd) begin
      regNext[FLAG_LSB +: FLD_W]  = excVec;
      regNext[CAUSE_LSB +: FLD_W] = causeNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stReg <= '0;
      tBit  <= 1'b0;
    end else begin
      stReg <= regNext;
      if (strb.tUpd) tBit <= strb.tVal;
    end
  end

  assign roundToZero = (stReg[RM_LSB +: RM_W] == RM_ZERO);
  assign flushDenorm = stReg[FLUSH_BIT];
endmodule

// File: rtl/fpu_exc_status.sv
module fpu_exc_status
  import fpexc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldEn,
  input  logic [REG_W-1:0]  ldData,
  input  logic              opDone,
  input  logic              excInvalid,
  input  logic              excDivZero,
  input  logic              excOverflow,
  input  logic              excUnderflow,
  input  logic              excInexact,
  input  logic              cmpDone,
  input  logic              cmpIsGt,
  input  logic              cmpEqual,
  input  logic              cmpGreater,
  input  logic              cmpUnordered,
  input  logic              trapAck,
  output logic [REG_W-1:0]  statusReg,
  output logic              tBit,
  output logic              roundToZero,
  output logic              flushDenorm,
  output logic              trapReq,
  output logic [CODE_W-1:0] trapCode
);
  strobe_t          strb;
  logic             trapHit;
  logic [FLD_W-1:0] excVec;

  assign excVec   = {excInvalid, excDivZero, excOverflow, excUnderflow, excInexact};
  assign trapCode = TRAP_CODE;

  fpexc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .opDone(opDone), .cmpDone(cmpDone),
    .cmpIsGt(cmpIsGt), .cmpEqual(cmpEqual), .cmpGreater(cmpGreater),
    .cmpUnordered(cmpUnordered), .trapAck(trapAck), .trapHit(trapHit),
    .strb(strb), .trapReq(trapReq)
  );

  fpexc_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ldData(ldData), .excVec(excVec),
    .stReg(statusReg), .tBit(tBit), .trapHit(trapHit),
    .roundToZero(roundToZero), .flushDenorm(flushDenorm)
  );
endmodule

// File: rtl/fpexc_chk.sv
module fpexc_chk
  import fpexc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ldEn,
  input logic [REG_W-1:0]  ldData,
  input logic              opDone,
  input logic              excInvalid,
  input logic              excDivZero,
  input logic              excOverflow,
  input logic              excUnderflow,
  input logic              excInexact,
  input logic              cmpDone,
  input logic              cmpIsGt,
  input logic              cmpEqual,
  input logic              cmpGreater,
  input logic              cmpUnordered,
  input logic              trapAck,
  input logic [REG_W-1:0]  statusReg,
  input logic              tBit,
  input logic              roundToZero,
  input logic              flushDenorm,
  input logic              trapReq,
  input logic [CODE_W-1:0] trapCode
);
  logic anyExc;
  logic excPath;
  assign anyExc  = excInvalid | excDivZero | excOverflow | excUnderflow | excInexact;
  assign excPath = !ldEn && (opDone || (cmpDone && cmpUnordered));

  // R2
  load_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldEn |=> (statusReg & ~WR_MASK) == '0);

  // R5
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    excPath |=> ((statusReg[CAUSE_LSB +: FLD_W] & $past(statusReg[CAUSE_LSB +: FLD_W]))
                 == $past(statusReg[CAUSE_LSB +: FLD_W])));

  // R7
  quiet_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excPath && !anyExc) |=> statusReg[FLAG_LSB +: FLD_W] == '0);

  // R6
  trap_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trapReq) |-> $past(excPath && anyExc));

  // R8
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && !trapAck) |=> trapReq);

  // R10
  unord_keep_t_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpDone && cmpUnordered && !ldEn && !opDone) |=> $stable(tBit));

  // R9
  ordered_t_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpDone && !cmpUnordered && !ldEn && !opDone) |=>
      (tBit == $past(cmpIsGt ? cmpGreater : cmpEqual)) && $stable(statusReg));
endmodule

bind fpu_exc_status fpexc_chk u_chk (.*);

// File: tb/sim_fpu_exc_status.sv
`timescale 1ns/1ps
module sim_fpu_exc_status;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldEn = 1'b0;
  logic [31:0] ldData = '0;
  logic        opDone = 1'b0;
  logic        excInvalid = 1'b0, excDivZero = 1'b0, excOverflow = 1'b0;
  logic        excUnderflow = 1'b0, excInexact = 1'b0;
  logic        cmpDone = 1'b0, cmpIsGt = 1'b0, cmpEqual = 1'b0;
  logic        cmpGreater = 1'b0, cmpUnordered = 1'b0;
  logic        trapAck = 1'b0;
  logic [31:0] statusReg;
  logic        tBit, roundToZero, flushDenorm, trapReq;
  logic [11:0] trapCode;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fpu_exc_status u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // exc order: {V,Z,O,U,I}
  task automatic setExc(input logic [4:0] e);
    {excInvalid, excDivZero, excOverflow, excUnderflow, excInexact} = e;
  endtask

  task automatic clearIn();
    ldEn = 0; opDone = 0; cmpDone = 0; trapAck = 0; setExc(5'b0);
    cmpIsGt = 0; cmpEqual = 0; cmpGreater = 0; cmpUnordered = 0;
  endtask

  task automatic load(input logic [31:0] v);
    @(negedge clk); ldEn = 1; ldData = v;
    @(negedge clk); clearIn();
  endtask

  task automatic op(input logic [4:0] e);
    @(negedge clk); opDone = 1; setExc(e);
    @(negedge clk); clearIn();
  endtask

  task automatic ack();
    @(negedge clk); trapAck = 1;
    @(negedge clk); clearIn();
  endtask

  task automatic cmp(input bit gt, input bit eq, input bit grt, input bit unord,
                     input logic [4:0] e);
    @(negedge clk); cmpDone = 1; cmpIsGt = gt; cmpEqual = eq; cmpGreater = grt;
    cmpUnordered = unord; setExc(e);
    @(negedge clk); clearIn();
  endtask

  function automatic logic [4:0] flagF(); return statusReg[6:2];   endfunction
  function automatic logic [4:0] causeF(); return statusReg[16:12]; endfunction

  task automatic t_reset();
    check(statusReg == 0 && tBit == 0 && trapReq == 0, "R1 reset",
          {statusReg[29:0], tBit, trapReq}, 32'h0);
  endtask

  task automatic t_load();
    load(32'hFFFF_FFFF);
    check(statusReg == 32'h0005_FFFF, "R2 masked load", statusReg, 32'h0005_FFFF);
    load(32'h0);
    // load wins over op in the same cycle
    @(negedge clk); ldEn = 1; ldData = 32'h0000_0080; opDone = 1; setExc(5'b11111);
    @(negedge clk); clearIn();
    check(statusReg == 32'h0000_0080, "R2 load priority", statusReg, 32'h80);
  endtask

  task automatic t_modes();
    load(32'h0000_0001);
    check(roundToZero == 1, "R3 rm=01 zero", {31'b0, roundToZero}, 1);
    load(32'h0000_0002);
    check(roundToZero == 0, "R3 rm=10 nearest", {31'b0, roundToZero}, 0);
    load(32'h0000_0003);
    check(roundToZero == 0, "R3 rm=11 nearest", {31'b0, roundToZero}, 0);
    load(32'h0004_0000);
    check(flushDenorm == 1 && roundToZero == 0, "R3 flush bit",
          {30'b0, flushDenorm, roundToZero}, 32'h2);
    load(32'h0);
    check(flushDenorm == 0, "R3 flush clear", {31'b0, flushDenorm}, 0);
  endtask

  task automatic t_flags();
    for (int i = 0; i < 5; i++) begin
      load(32'h0);
      op(5'(1 << i));
      check(flagF() == 5'(1 << i), "R4 flag mapping", {27'b0, flagF()}, 32'(1 << i));
    end
    load(32'h0);
    op(5'b10000);
    op(5'b00011);
    check(flagF() == 5'b00011, "R4 flags rewritten", {27'b0, flagF()}, 32'h3);
    check(causeF() == 5'b10011, "R5 cause accumulates", {27'b0, causeF()}, 32'h13);
    check(trapReq == 0, "R6 no trap without enable", {31'b0, trapReq}, 0);
  endtask

  task automatic t_trap();
    load(32'h0000_0400);   // enable divide-by-zero (enable bit 3 -> reg bit 10)
    op(5'b01000);
    check(trapReq == 1 && trapCode == 12'h120, "R6 trap raised",
          {19'b0, trapReq, trapCode}, 32'h1120);
    repeat (3) @(negedge clk);
    check(trapReq == 1, "R8 trap held", {31'b0, trapReq}, 1);
    ack();
    check(trapReq == 0, "R8 ack clears", {31'b0, trapReq}, 0);
    // old cause overlapping enable plus any new exception traps
    load(32'h0001_0800);   // cause invalid + enable invalid
    op(5'b00001);
    check(trapReq == 1, "R6 trap from earlier cause", {31'b0, trapReq}, 1);
    // new trap in ack cycle wins
    @(negedge clk); trapAck = 1; opDone = 1; setExc(5'b00001);
    @(negedge clk); clearIn();
    check(trapReq == 1, "R8 set beats ack", {31'b0, trapReq}, 1);
    ack();
    op(5'b00000);
    check(trapReq == 0 && flagF() == 0 && causeF() == 5'b10001, "R7 quiet op",
          {trapReq, 26'b0, flagF()}, 32'h0);
  endtask

  task automatic t_cmp();
    load(32'h0);
    cmp(0, 1, 0, 0, 5'b0);
    check(tBit == 1 && statusReg == 0, "R9 eq true", {31'b0, tBit}, 1);
    cmp(1, 1, 0, 0, 5'b0);
    check(tBit == 0, "R9 gt false", {31'b0, tBit}, 0);
    cmp(1, 0, 1, 0, 5'b0);
    check(tBit == 1, "R9 gt true", {31'b0, tBit}, 1);
    cmp(0, 0, 0, 1, 5'b10000);
    check(tBit == 1 && flagF() == 5'b10000 && causeF() == 5'b10000,
          "R10 unordered", {tBit, 26'b0, flagF()}, 32'h8000_0010);
    // op has priority over ordered compare
    @(negedge clk); opDone = 1; cmpDone = 1; cmpEqual = 0; cmpIsGt = 0;
    @(negedge clk); clearIn();
    check(tBit == 1 && flagF() == 0, "R9 op over compare", {31'b0, tBit}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    t_load();
    t_modes();
    t_flags();
    t_trap();
    t_cmp();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule